// File: doc/BRIEF.md
# Space-Vector Sector and Dwell-Time Calculator

This block turns a reference voltage vector for a two-level three-phase inverter into the timing of one switching period. It receives a magnitude, normalised so that 1.0 is the largest circle that fits inside the hexagon of active vectors, an electrical angle as a 16-bit fraction of a full turn, and the period length in clock ticks. It returns the 60-degree sector (1 to 6, counter-clockwise) that holds the vector, the on-times of the two active vectors that bound the sector, and the zero-vector time that is left over.

The angle is reduced by a multiply-by-six rather than a divider. The upper bits give the sector and the lower bits give the angle inside the sector. Both sine terms come from one quarter-wave table with linear interpolation. When the two active times together exceed the period, the reference lies outside the hexagon. The block then scales both times by the same factor so that they fill the period exactly, and the zero time becomes 0.

Requests arrive on a valid/ready handshake, and only one request is in flight at a time. A result is held on the outputs, unchanged, until the consumer takes it at the start of its next period.

Top module: `svm_dwell_calc`

## Requirements
- R1: `sector` equals floor(angle*6/65536)+1. Sector 1 starts at angle 0, and the sector number rises counter-clockwise up to 6.
- R2: The in-sector angle is theta = ((angle*6) mod 65536)/65536 * 60 degrees. When the result is not clamped, `t_first` is within 1 tick of m*T*sin(60deg - theta). Here m = ref_mag/16384 (unsigned, 14 fraction bits, 16384 = inscribed circle) and T = period_ticks.
- R3: When the result is not clamped, `t_second` is within 1 tick of m*T*sin(theta).
- R4: When the result is not clamped, `clamped` is 0 and `t_zero` is exactly T - t_first - t_second.
- R5: When m*T*(sin(60deg-theta)+sin(theta)) exceeds T, `clamped` is 1 and `t_zero` is 0. In that case `t_first + t_second` equals T exactly, and `t_first` is within 1 tick of T*sin(60deg-theta)/(sin(60deg-theta)+sin(theta)).
- R6: At theta = 0, `t_second` is exactly 0. Just below a sector edge (theta near 60 degrees), `t_first` is at most 1.
- R7: `req_ready` is high only when no request is in flight, and a request is taken on a clock edge with `req_valid` and `req_ready` both high. `res_valid` stays high, and every result output stays unchanged, until an edge with `res_ready` high.
- R8: After reset, `req_ready` is 1 and `res_valid` is 0.
- R9: A magnitude of 0 gives `t_first` = `t_second` = 0 and `t_zero` = T exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request is present |
| req_ready | output | 1 | Block can take a request |
| ref_mag | input | 16 | Reference magnitude, unsigned, 14 fraction bits |
| ref_angle | input | 16 | Reference angle, fraction of a full turn |
| period_ticks | input | 16 | Switching period in clock ticks |
| res_valid | output | 1 | Result is present |
| res_ready | input | 1 | Consumer takes the result |
| sector | output | 3 | Sector number 1..6 |
| t_first | output | 16 | On-time of the first active vector of the sector |
| t_second | output | 16 | On-time of the second active vector of the sector |
| t_zero | output | 16 | Zero-vector time |
| clamped | output | 1 | Reference was outside the hexagon and was scaled back |

## Verification
The assertions assume that the consumer moves `res_ready` only through the handshake, and that the period is nonzero. They also assume that magnitudes stay below 4.0, so that the active times fit the internal width. The stimulus draws periods between 100 and 4000 ticks and keeps magnitudes at or below 2.0. Random magnitudes are taken from two bands, one with m at most 0.85 and one with m at least 1.25. The clamp decision therefore never falls within rounding distance of the hexagon edge, except in directed cases where the flag is deliberately not compared.

// File: rtl/svm_dwell_pkg.sv
package svm_dwell_pkg;

  localparam int SIN_W      = 16;
  localparam int LUT_ADDR_W = 8;
  localparam int LUT_N      = 1 << LUT_ADDR_W;
  localparam int POS_W      = 16;
  // 60 degrees expressed in quarter-wave table positions (Q8.8): 256*2/3
  localparam longint SPAN_POS = 43691;

  typedef logic [2:0] sector_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_CHECK,
    ST_SCALE,
    ST_HOLD
  } dwell_state_e;

  // Quarter-wave sine, LUT_N+1 points over [0, 90deg], unsigned Q0.16.
  // Taylor series in Q30 integer arithmetic, evaluated at elaboration.
  function automatic logic [(LUT_N+1)*SIN_W-1:0] build_quarter_sine();
    logic [(LUT_N+1)*SIN_W-1:0] tab;
    longint x, term, acc, q;
    tab = '0;
    for (int i = 0; i <= LUT_N; i++) begin
      x    = (longint'(i) * 64'sd1686629713) / longint'(LUT_N);
      acc  = x;
      term = x;
      for (int k = 1; k <= 7; k++) begin
        term = -((((term * x) >>> 30) * x) >>> 30) / longint'((2 * k) * (2 * k + 1));
        acc  = acc + term;
      end
      q = (acc + 64'sd8192) >>> 14;
      if (q > 64'sd65535) q = 64'sd65535;
      if (q < 64'sd0) q = 64'sd0;
      tab[i*SIN_W +: SIN_W] = q[SIN_W-1:0];
    end
    return tab;
  endfunction

  // Linear interpolation between neighbouring table points; pos is Q8.8.
  function automatic logic [SIN_W-1:0] sine_interp(
      input logic [(LUT_N+1)*SIN_W-1:0] tab,
      input logic [POS_W-1:0] pos);
    logic [LUT_ADDR_W-1:0] idx;
    logic [7:0]            fr;
    logic [SIN_W-1:0]      lo, hi, step;
    logic [SIN_W+7:0]      slope;
    idx   = pos[POS_W-1 -: LUT_ADDR_W];
    fr    = pos[7:0];
    lo    = tab[int'(idx)*SIN_W +: SIN_W];
    hi    = tab[(int'(idx)+1)*SIN_W +: SIN_W];
    step  = hi - lo;
    slope = (SIN_W+8)'(step) * (SIN_W+8)'(fr) + (SIN_W+8)'(128);
    return lo + slope[SIN_W+7:8];
  endfunction

  // Rounded product m * T * s, where m has mag_frac fraction bits, s is Q0.SIN_W.
  function automatic logic [63:0] dwell_product(
      input logic [63:0] mag, input logic [63:0] per,
      input logic [63:0] sine, input int mag_frac);
    logic [63:0] p;
    p = mag * per * sine;
    return (p + (64'd1 << (mag_frac + SIN_W - 1))) >> (mag_frac + SIN_W);
  endfunction

endpackage

// File: rtl/svm_angle_split.sv
module svm_angle_split
  import svm_dwell_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic [ANGLE_W-1:0] angle,
  output sector_t            sector_num,
  output logic [ANGLE_W:0]   ang_lead,
  output logic [ANGLE_W:0]   ang_trail
);
  localparam logic [ANGLE_W:0] SECTOR_SPAN = {1'b1, {ANGLE_W{1'b0}}};

  logic [ANGLE_W+2:0] scaled;

  // angle * 6 = (angle << 2) + (angle << 1); top three bits give the sector
  assign scaled     = ({3'b000, angle} << 2) + ({3'b000, angle} << 1);
  assign sector_num = sector_t'(scaled[ANGLE_W+2:ANGLE_W]) + sector_t'(1);
  assign ang_lead   = {1'b0, scaled[ANGLE_W-1:0]};
  assign ang_trail  = SECTOR_SPAN - ang_lead;
endmodule

// File: rtl/svm_sine_lut.sv
module svm_sine_lut
  import svm_dwell_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic [ANGLE_W:0]  ang,
  output logic [SIN_W-1:0]  sine
);
  localparam logic [(LUT_N+1)*SIN_W-1:0] QTAB = build_quarter_sine();
  localparam int PW = ANGLE_W + 1 + 17;

  logic [PW-1:0]    scaled;
  logic [POS_W-1:0] pos;

  // map 0..2^ANGLE_W (0..60deg) to table position 0..SPAN_POS (Q8.8)
  assign scaled = PW'(ang) * PW'(SPAN_POS);
  assign pos    = POS_W'(scaled >> ANGLE_W);
  assign sine   = sine_interp(QTAB, pos);
endmodule

// File: rtl/svm_dwell_mul.sv
module svm_dwell_mul
  import svm_dwell_pkg::*;
#(
  parameter int MAG_W    = 16,
  parameter int MAG_FRAC = 14,
  parameter int PERIOD_W = 16,
  parameter int RAW_W    = PERIOD_W + MAG_W - MAG_FRAC
) (
  input  logic [MAG_W-1:0]    mag,
  input  logic [PERIOD_W-1:0] period,
  input  logic [SIN_W-1:0]    sine,
  output logic [RAW_W-1:0]    dwell
);
  logic [63:0] full;
  assign full  = dwell_product(64'(mag), 64'(period), 64'(sine), MAG_FRAC);
  assign dwell = full[RAW_W-1:0];
endmodule

// File: rtl/svm_clamp_div.sv
module svm_clamp_div #(
  parameter int NUM_W  = 36,
  parameter int DEN_W  = 20,
  parameter int QUOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_W-1:0]  num,
  input  logic [DEN_W-1:0]  den,
  output logic              busy,
  output logic              done,
  output logic [QUOT_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   shifted;
  logic             fits;

  assign shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den_q};
  assign quot    = quo_q[QUOT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num;
        den_q <= den;
        cnt_q <= CNT_W'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? (shifted - {1'b0, den_q}) : shifted;
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5: the clamp divider is never restarted mid-run and signals completion once
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc
  import svm_dwell_pkg::*;
#(
  parameter int ANGLE_W  = 16,
  parameter int MAG_W    = 16,
  parameter int MAG_FRAC = 14,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [MAG_W-1:0]    ref_mag,
  input  logic [ANGLE_W-1:0]  ref_angle,
  input  logic [PERIOD_W-1:0] period_ticks,
  output logic                res_valid,
  input  logic                res_ready,
  output sector_t             sector,
  output logic [PERIOD_W-1:0] t_first,
  output logic [PERIOD_W-1:0] t_second,
  output logic [PERIOD_W-1:0] t_zero,
  output logic                clamped
);
  localparam int RAW_W = PERIOD_W + MAG_W - MAG_FRAC;
  localparam int SUM_W = RAW_W + 1;
  localparam int NUM_W = RAW_W + PERIOD_W + 2;
  localparam int DEN_W = SUM_W + 1;

  dwell_state_e state_q;

  logic [MAG_W-1:0]    mag_q;
  logic [ANGLE_W-1:0]  ang_q;
  logic [PERIOD_W-1:0] per_q;
  sector_t             sector_w;
  logic [ANGLE_W:0]    ang_path [2];
  logic [SIN_W-1:0]    sine_w   [2];
  logic [RAW_W-1:0]    raw_w    [2];
  logic [RAW_W-1:0]    raw_q    [2];
  sector_t             sector_q;

  // named internal events for the checks below
  logic                accept_evt, release_evt, over_hex, div_start, div_busy, div_done;
  logic [SUM_W-1:0]    raw_sum;
  logic [NUM_W-1:0]    div_num;
  logic [DEN_W-1:0]    div_den;
  logic [PERIOD_W-1:0] div_quot;

  svm_angle_split #(.ANGLE_W(ANGLE_W)) u_split (
    .angle      (ang_q),
    .sector_num (sector_w),
    .ang_lead   (ang_path[1]),
    .ang_trail  (ang_path[0])
  );

  // path 0: first active vector, sin(60 - theta); path 1: second, sin(theta)
  for (genvar g = 0; g < 2; g++) begin : g_path
    svm_sine_lut #(.ANGLE_W(ANGLE_W)) u_lut (
      .ang  (ang_path[g]),
      .sine (sine_w[g])
    );
    svm_dwell_mul #(
      .MAG_W(MAG_W), .MAG_FRAC(MAG_FRAC), .PERIOD_W(PERIOD_W), .RAW_W(RAW_W)
    ) u_mul (
      .mag    (mag_q),
      .period (per_q),
      .sine   (sine_w[g]),
      .dwell  (raw_w[g])
    );
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign res_valid   = (state_q == ST_HOLD);
  assign accept_evt  = req_valid && req_ready;
  assign release_evt = res_valid && res_ready;
  assign raw_sum     = SUM_W'(raw_q[0]) + SUM_W'(raw_q[1]);
  assign over_hex    = raw_sum > SUM_W'(per_q);
  assign div_start   = (state_q == ST_CHECK) && over_hex;
  assign div_num     = NUM_W'(raw_q[0]) * NUM_W'(per_q) * NUM_W'(2) + NUM_W'(raw_sum);
  assign div_den     = {raw_sum, 1'b0};

  svm_clamp_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QUOT_W(PERIOD_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mag_q    <= '0;
      ang_q    <= '0;
      per_q    <= '0;
      raw_q[0] <= '0;
      raw_q[1] <= '0;
      sector_q <= sector_t'(1);
      sector   <= sector_t'(1);
      t_first  <= '0;
      t_second <= '0;
      t_zero   <= '0;
      clamped  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_evt) begin
          mag_q   <= ref_mag;
          ang_q   <= ref_angle;
          per_q   <= period_ticks;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          raw_q[0] <= raw_w[0];
          raw_q[1] <= raw_w[1];
          sector_q <= sector_w;
          state_q  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (over_hex) begin
            state_q <= ST_SCALE;
          end else begin
            sector   <= sector_q;
            t_first  <= raw_q[0][PERIOD_W-1:0];
            t_second <= raw_q[1][PERIOD_W-1:0];
            t_zero   <= per_q - raw_sum[PERIOD_W-1:0];
            clamped  <= 1'b0;
            state_q  <= ST_HOLD;
          end
        end
        ST_SCALE: if (div_done) begin
          sector   <= sector_q;
          t_first  <= div_quot;
          t_second <= per_q - div_quot;
          t_zero   <= '0;
          clamped  <= 1'b1;
          state_q  <= ST_HOLD;
        end
        ST_HOLD: if (release_evt) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: result is frozen while waiting for the consumer
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(t_first) && $stable(t_second)
      && $stable(t_zero) && $stable(sector) && $stable(clamped)));
  // R7: never a new request while a result is pending
  a_r7_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));
  // R7: a taken request leaves the idle state
  a_r7_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);
  // R1: sector stays within 1..6
  a_r1_sector_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (sector >= sector_t'(1) && sector <= sector_t'(6)));
  // R5: a clamped result leaves no zero time and fills the period
  a_r5_clamp_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && clamped) |-> (t_zero == '0 && (t_first + t_second) == per_q));
  // R4: times of an unclamped result add up to the latched period
  a_r4_sum_period: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !clamped) |-> ((PERIOD_W+2)'(t_first) + (PERIOD_W+2)'(t_second)
      + (PERIOD_W+2)'(t_zero)) == (PERIOD_W+2)'(per_q));
  // R5: the divider only runs while scaling back
  a_r5_div_in_scale: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (state_q == ST_SCALE));
endmodule

// File: tb/tb_svm_dwell_calc.sv
module tb_svm_dwell_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] ref_mag = '0;
  logic [15:0] ref_angle = '0;
  logic [15:0] period_ticks = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [2:0]  sector;
  logic [15:0] t_first, t_second, t_zero;
  logic        clamped;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  localparam real PI = 3.14159265358979;

  always #5 clk = ~clk;

  svm_dwell_calc dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .ref_mag(ref_mag), .ref_angle(ref_angle), .period_ticks(period_ticks),
    .res_valid(res_valid), .res_ready(res_ready), .sector(sector),
    .t_first(t_first), .t_second(t_second), .t_zero(t_zero), .clamped(clamped)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check_int(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input real exp);
    real d;
    n_checks++;
    d = real'(act) - exp;
    if (d > 1.0 || d < -1.0) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %f", req, act, exp);
    end
  endtask

  // model from the requirements: returns sector, ideal times, clamp decision
  task automatic model(input int mag, input int ang, input int per,
                       output int sec, output real e1, output real e2, output bit clp);
    real m, th, s;
    sec = ((ang * 6) / 65536) + 1;
    th  = real'((ang * 6) % 65536) / 65536.0 * (PI / 3.0);
    m   = real'(mag) / 16384.0;
    e1  = m * real'(per) * $sin(PI / 3.0 - th);
    e2  = m * real'(per) * $sin(th);
    s   = e1 + e2;
    clp = (s > real'(per));
    if (clp) begin
      e1 = real'(per) * e1 / s;
      e2 = real'(per) - e1;
    end
  endtask

  task automatic issue(input int mag, input int ang, input int per);
    @(negedge clk);
    ref_mag = 16'(mag); ref_angle = 16'(ang); period_ticks = 16'(per);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
  endtask

  task automatic take;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  // full comparison; chk_flag = 0 leaves the clamp flag unchecked near the edge
  task automatic run_case(input int mag, input int ang, input int per, input bit chk_flag);
    int sec; real e1, e2; bit clp;
    model(mag, ang, per, sec, e1, e2, clp);
    issue(mag, ang, per);
    check_int("R1 sector", int'(sector), sec);
    if (chk_flag && clp) begin
      check_int("R5 clamped flag", int'(clamped), 1);
      check_int("R5 zero time", int'(t_zero), 0);
      check_int("R5 fill period", int'(t_first) + int'(t_second), per);
      check_near("R5 scaled t_first", int'(t_first), e1);
    end else begin
      check_near("R2 t_first", int'(t_first), e1);
      check_near("R3 t_second", int'(t_second), e2);
      if (chk_flag) begin
        check_int("R4 clamped flag", int'(clamped), 0);
        check_int("R4 zero time", int'(t_zero), per - int'(t_first) - int'(t_second));
      end else begin
        check_int("R4 period sum", int'(t_zero) + int'(t_first) + int'(t_second), per);
      end
    end
    take();
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    #1;
    // R8 reset state
    check_int("R8 req_ready", int'(req_ready), 1);
    check_int("R8 res_valid", int'(res_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_int("R8 req_ready after release", int'(req_ready), 1);
    check_int("R8 res_valid after release", int'(res_valid), 0);

    // R6 sector edges
    issue(16384, 0, 2000);
    check_int("R6 theta0 t_second", int'(t_second), 0);
    check_near("R6 theta0 t_first", int'(t_first), 2000.0 * $sin(PI / 3.0));
    check_int("R1 theta0 sector", int'(sector), 1);
    take();
    issue(12000, 10922, 3000);
    check_int("R6 near60 t_first small", int'(t_first <= 16'd1), 1);
    check_int("R1 near60 sector", int'(sector), 1);
    take();
    run_case(12000, 10923, 3000, 1'b1);   // just into sector 2
    run_case(12000, 65535, 3000, 1'b1);   // last angle of sector 6
    run_case(16384, 5461, 2500, 1'b0);    // inscribed circle at mid-sector
    run_case(30000, 0, 1000, 1'b1);       // clamp with a single active vector

    // R9 zero magnitude
    issue(0, 20000, 1234);
    check_int("R9 t_first", int'(t_first), 0);
    check_int("R9 t_second", int'(t_second), 0);
    check_int("R9 t_zero", int'(t_zero), 1234);
    take();

    // R7 hold: result stays put while res_ready is low, no new request taken
    begin
      logic [15:0] h1, h2, h0; logic [2:0] hs;
      issue(9000, 40000, 3500);
      h1 = t_first; h2 = t_second; h0 = t_zero; hs = sector;
      ref_angle = 16'd100; ref_mag = 16'd30000; req_valid = 1'b1;
      repeat (6) @(negedge clk);
      check_int("R7 held res_valid", int'(res_valid), 1);
      check_int("R7 no ready while pending", int'(req_ready), 0);
      check_int("R7 held t_first", int'(t_first), int'(h1));
      check_int("R7 held t_second", int'(t_second), int'(h2));
      check_int("R7 held t_zero", int'(t_zero), int'(h0));
      check_int("R7 held sector", int'(sector), int'(hs));
      req_valid = 1'b0;
      take();
      check_int("R7 ready after release", int'(req_ready), 1);
    end

    // random: unclamped band and clamped band
    for (int i = 0; i < 40; i++) begin
      run_case(int'($urandom_range(13926, 0)), int'($urandom_range(65535, 0)),
               int'($urandom_range(4000, 100)), 1'b1);
    end
    for (int i = 0; i < 40; i++) begin
      run_case(int'($urandom_range(32768, 20480)), int'($urandom_range(65535, 0)),
               int'($urandom_range(4000, 100)), 1'b1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule